// File: doc/BRIEF.md
# Two-Channel Output Compare Timer

A 16-bit up-counter with two compare channels, reached through an 8-bit register bus. The timer clock comes from a selectable source. One choice is the system clock divided by 2, 4 or 8. The other is an external clock pin, which passes through a two-flop synchronizer and advances the counter once per detected rising edge.

Each channel keeps a 16-bit compare value that software writes one byte at a time. Whenever the counter equals that value, the channel sets a sticky flag. If the channel's pin is enabled, the same match copies a programmed level onto its output pin. A shared enable lets the flags drive a level interrupt request.

A write to a channel's high compare byte holds off that channel's compares until the low byte has been written. This keeps a half-updated value from producing a false match. A flag is cleared by a two-step handshake: read the status register while the flag is set, then access that channel's low compare byte.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset, the counter reads 0000h, both compare values read FFFFh, the control and status registers read 00h, and both pins and the interrupt are 0.
- R2: With control bits [1:0] = 0, 1 or 2, the counter advances by exactly one every 2, 4 or 8 clock cycles.
- R3: With control bits [1:0] = 3, the counter advances by exactly one for each rising edge of `ext_clk`, however long the pin stays high, and holds otherwise.
- R4: While a channel's compare is enabled and the counter equals its compare value, the channel's status flag is set. Status bit 0 is channel 0 and bit 1 is channel 1.
- R5: On a match, a channel whose output-enable bit is set (control bit 3 for channel 0, bit 4 for channel 1) drives its pin to its level bit (control bit 5 or 6). With output-enable clear, the pin keeps its value but the flag still sets.
- R6: A write to a channel's high compare byte disables that channel's compares, and a later write to its low compare byte enables them again.
- R7: A flag clears only when an access (read or write) to that channel's low compare byte follows a status read that saw the flag set. An access to the low byte without that earlier status read leaves the flag set.
- R8: A status read that sees a channel's flag clear cancels that channel's pending clear, so a flag that sets afterwards survives a low-byte access.
- R9: `irq` is 1 exactly when control bit 2 is set and at least one flag is set. It stays high until the flags are cleared.
- R10: Register addresses are: 0 control, 1 status, 2 and 3 counter high and low byte, 4 and 5 channel 0 compare high and low byte, 6 and 7 channel 1 compare high and low byte. Control and compare bytes read back what was written. `bus_rdata` shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; its side effects happen at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ext_clk | input | 1 | Asynchronous external timer clock |
| cmp_pin | output | 2 | Compare output pins, one per channel |
| irq | output | 1 | Level interrupt request |

## Verification
The bench first freezes the counter by selecting the external source with the pin idle. It then steps the counter one pulse at a time, so every match happens at a count it knows.

A random loop covers several kinds of stimulus:
- Compare targets placed 0 to 5 steps ahead of the counter. A target at 0 steps checks a match on a value that is already equal; targets further ahead check that the flag stays clear until the step that reaches them.
- Random pin levels, which show whether the pin copies the level bit.
- Random interrupt enables, which show whether the interrupt is gated.

Directed cases cover the situations the random loop does not reach:
- A compare value that already equals the counter while only its high byte has been written, to show that the compare is held off.
- A low-byte access with no status read before it, and one that follows a status read taken while the flag was clear, to show that both leave the flag set.
- Fixed windows of 64 cycles under each divide setting, and long and short external pulses, which separate the divide ratios and the edge counting.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int DW  = 8;
    localparam int CW  = 16;
    localparam int NCH = 2;
    localparam int AW  = 4;

    typedef enum logic [1:0] {
        SRC_DIV2 = 2'd0,
        SRC_DIV4 = 2'd1,
        SRC_DIV8 = 2'd2,
        SRC_EXT  = 2'd3
    } clk_src_e;

    // control byte: [6:5] pin levels, [4:3] pin enables, [2] irq enable, [1:0] source
    typedef struct packed {
        logic [NCH-1:0] lvl;
        logic [NCH-1:0] oe;
        logic           irq_en;
        clk_src_e       src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_STAT = AW'(1);
    localparam logic [AW-1:0] A_CNTH = AW'(2);
    localparam logic [AW-1:0] A_CNTL = AW'(3);
    localparam int            A_CH0  = 4;

    function automatic logic [AW-1:0] hi_addr(input int ch);
        return AW'(A_CH0 + 2 * ch);
    endfunction

    function automatic logic [AW-1:0] lo_addr(input int ch);
        return AW'(A_CH0 + 2 * ch + 1);
    endfunction

    // per-channel bus strobes decoded in the top
    typedef struct packed {
        logic          hi_wr;
        logic          lo_wr;
        logic          lo_acc;
        logic          stat_rd;
        logic [DW-1:0] data;
    } chan_bus_t;

endpackage

// File: rtl/cmp_tmr_tick.sv
module cmp_tmr_tick
    import cmp_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e src,
    input  logic     ext_clk,
    output logic     tick
);

    localparam int DIVW  = 3;
    localparam int SYNCN = 3;

    logic [DIVW-1:0]  div_q;
    logic [SYNCN-1:0] sync_q;
    logic             ext_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            sync_q <= '0;
        end else begin
            div_q  <= div_q + 1'b1;
            sync_q <= {sync_q[SYNCN-2:0], ext_clk};
        end
    end

    // sync_q[1] is the second synchronizer flop, sync_q[2] its delayed copy
    assign ext_rise = sync_q[1] & ~sync_q[2];

    always_comb begin
        case (src)
            SRC_DIV2: tick = div_q[0];
            SRC_DIV4: tick = &div_q[1:0];
            SRC_DIV8: tick = &div_q;
            default:  tick = ext_rise;
        endcase
    end

endmodule

// File: rtl/cmp_tmr_chan.sv
module cmp_tmr_chan
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = CW,
    parameter int BYTE_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  chan_bus_t         bus,
    input  logic              oe,
    input  logic              lvl,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag,
    output logic              pin
);

    logic en_q;
    logic armed_q;
    logic match;

    assign match = en_q && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp     <= '1;
            en_q    <= 1'b1;
            armed_q <= 1'b0;
            flag    <= 1'b0;
            pin     <= 1'b0;
        end else begin
            if (bus.hi_wr) begin
                cmp[CNT_W-1:BYTE_W] <= bus.data;
                en_q                <= 1'b0;
            end
            if (bus.lo_wr) begin
                cmp[BYTE_W-1:0] <= bus.data;
                en_q            <= 1'b1;
            end
            if (bus.stat_rd)
                armed_q <= flag;
            else if (bus.lo_acc)
                armed_q <= 1'b0;
            if (match)
                flag <= 1'b1;
            else if (bus.lo_acc && armed_q)
                flag <= 1'b0;
            if (match && oe)
                pin <= lvl;
        end
    end

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);                                            // R4
    AST_PIN_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        !(match && oe) |=> $stable(pin));                           // R5
    AST_HI_WRITE_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !$rose(flag));                                    // R6
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(armed_q));                            // R7
    AST_ARM_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (bus.stat_rd && !flag) |=> !armed_q);                       // R8

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = CW,
    parameter int BYTE_W = DW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk,
    output logic [NCH-1:0]    cmp_pin,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic [NCH-1:0]   flags;
    logic [CNT_W-1:0] cmp_v [NCH];

    cmp_tmr_tick u_tick (
        .clk     (clk),
        .rst     (rst),
        .src     (ctrl_q.src),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            chan_bus_t cb;
            always_comb begin
                cb.hi_wr   = bus_wr && (bus_addr == ADDR_W'(hi_addr(c)));
                cb.lo_wr   = bus_wr && (bus_addr == ADDR_W'(lo_addr(c)));
                cb.lo_acc  = (bus_wr || bus_rd) && (bus_addr == ADDR_W'(lo_addr(c)));
                cb.stat_rd = bus_rd && (bus_addr == ADDR_W'(A_STAT));
                cb.data    = bus_wdata;
            end
            cmp_tmr_chan #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ch (
                .clk  (clk),
                .rst  (rst),
                .cnt  (cnt_q),
                .bus  (cb),
                .oe   (ctrl_q.oe[c]),
                .lvl  (ctrl_q.lvl[c]),
                .cmp  (cmp_v[c]),
                .flag (flags[c]),
                .pin  (cmp_pin[c])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_CTRL): bus_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_W'(A_STAT): bus_rdata[NCH-1:0]    = flags;
            ADDR_W'(A_CNTH): bus_rdata             = cnt_q[CNT_W-1:BYTE_W];
            ADDR_W'(A_CNTL): bus_rdata             = cnt_q[BYTE_W-1:0];
            default: ;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(hi_addr(c))) bus_rdata = cmp_v[c][CNT_W-1:BYTE_W];
            if (bus_addr == ADDR_W'(lo_addr(c))) bus_rdata = cmp_v[c][BYTE_W-1:0];
        end
    end

    assign irq = ctrl_q.irq_en && (|flags);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == $past(cnt_q) + 1'b1);                     // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));                                  // R3

endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic [1:0] cmp_pin;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    cmp_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_clk   (ext_clk),
        .cmp_pin   (cmp_pin),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] h, l;
        rd(4'd2, h);
        rd(4'd3, l);
        v = {h, l};
    endtask

    task automatic pulse();
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // control byte built from the requirement fields
    function automatic logic [7:0] ctrl_byte(input logic [1:0] src, input logic ie,
                                             input logic [1:0] oe, input logic [1:0] lv);
        return {1'b0, lv, oe, ie, src};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] c, t, a, b;
        logic [7:0]  s, x;
        void'($urandom(32'h5EED));

        // R1: reset state, observed combinationally while reset holds
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_addr = 4'd2; #1 chk("R1 cnt hi", bus_rdata, 8'h00);
        bus_addr = 4'd3; #1 chk("R1 cnt lo", bus_rdata, 8'h00);
        bus_addr = 4'd4; #1 chk("R1 cmp0 hi", bus_rdata, 8'hFF);
        bus_addr = 4'd5; #1 chk("R1 cmp0 lo", bus_rdata, 8'hFF);
        bus_addr = 4'd6; #1 chk("R1 cmp1 hi", bus_rdata, 8'hFF);
        bus_addr = 4'd7; #1 chk("R1 cmp1 lo", bus_rdata, 8'hFF);
        bus_addr = 4'd0; #1 chk("R1 ctrl", bus_rdata, 8'h00);
        bus_addr = 4'd1; #1 chk("R1 status", bus_rdata, 8'h00);
        chk("R1 pins", cmp_pin, 2'b00);
        chk("R1 irq", irq, 1'b0);
        rst = 1'b0;

        // freeze the counter: external source, pin idle
        wr(4'd0, ctrl_byte(2'd3, 1'b1, 2'b00, 2'b00));
        rd(4'd0, s);
        chk("R10 ctrl readback", s, 8'h07);
        rd_cnt(c);

        // R6: high byte write holds compares off until the low byte
        wr(4'd4, ~c[15:8]);
        wr(4'd5, c[7:0]);
        wait_n(3);
        chk("R6 setup no match", irq, 1'b0);
        wr(4'd4, c[15:8]);
        wait_n(4);
        chk("R6 inhibited after hi write", irq, 1'b0);
        rd(4'd4, s);
        chk("R10 cmp0 hi readback", s, c[15:8]);
        wr(4'd5, c[7:0]);
        wait_n(2);
        chk("R6 enabled by lo write", irq, 1'b1);

        // R7: low access without armed status read does not clear
        pulse(); c = c + 1'b1;
        rd(4'd5, x);
        wait_n(2);
        chk("R7 no clear without status read", irq, 1'b1);
        rd(4'd1, s);
        chk("R4 status bit0", s[0], 1'b1);
        rd(4'd5, x);
        wait_n(1);
        chk("R7 cleared by status then lo read", irq, 1'b0);

        // R8: status read on a clear flag cancels the pending clear
        t = c + 1'b1;
        wr(4'd4, t[15:8]);
        wr(4'd5, t[7:0]);
        rd(4'd1, s);
        chk("R8 flag clear at status read", s[0], 1'b0);
        pulse(); c = c + 1'b1;
        wait_n(2);
        chk("R4 match by ext step", irq, 1'b1);
        rd(4'd5, x);
        wait_n(2);
        chk("R8 flag survives lo read", irq, 1'b1);
        pulse(); c = c + 1'b1;
        rd(4'd1, s);
        wr(4'd5, t[7:0]);
        wait_n(2);
        chk("R7 cleared by status then lo write", irq, 1'b0);

        // R5 / R9: pin enable and interrupt gating
        wr(4'd0, ctrl_byte(2'd3, 1'b0, 2'b01, 2'b11));
        wr(4'd6, c[15:8]); wr(4'd7, c[7:0]);
        wr(4'd4, c[15:8]); wr(4'd5, c[7:0]);
        wait_n(3);
        chk("R5 pin1 not driven with oe clear", cmp_pin[1], 1'b0);
        chk("R5 pin0 driven to level", cmp_pin[0], 1'b1);
        chk("R9 irq gated off", irq, 1'b0);
        rd(4'd1, s);
        chk("R5 flags still set", s, 8'h03);
        rd(4'd7, s);
        chk("R10 cmp1 lo readback", s, c[7:0]);
        wr(4'd0, ctrl_byte(2'd3, 1'b1, 2'b01, 2'b11));
        wait_n(1);
        chk("R9 irq with enable", irq, 1'b1);

        // random compare targets ahead of the stepped counter
        for (int it = 0; it < 24; it++) begin
            int         ch = $urandom % 2;
            int         d  = $urandom % 6;
            logic [1:0] lv = 2'($urandom % 4);
            logic       ie = 1'($urandom % 2);
            wr(4'd0, ctrl_byte(2'd3, ie, 2'b11, lv));
            t = c + 16'(d);
            wr(4'(4 + 2 * ch), t[15:8]);
            rd(4'd1, s);
            wr(4'(5 + 2 * ch), t[7:0]);
            wait_n(2);
            if (d > 0) begin
                rd(4'd1, s);
                chk("R7 sequence clears flag", s[ch], 1'b0);
            end
            for (int k = 0; k < d; k++) begin
                pulse(); c = c + 1'b1;
                if (k < d - 1) begin
                    rd(4'd1, s);
                    chk("R4 no flag before target", s[ch], 1'b0);
                end
            end
            wait_n(3);
            rd(4'd1, s);
            chk("R4 flag at target", s[ch], 1'b1);
            chk("R5 pin follows level", cmp_pin[ch], lv[ch]);
            chk("R9 irq follows enable", irq, ie);
        end

        // R2: 64-cycle windows under each divide setting
        for (int k = 0; k < 3; k++) begin
            rd_cnt(a);
            wr(4'd0, 8'(k));
            wait_n(62);
            wr(4'd0, 8'd3);
            rd_cnt(b);
            chk("R2 divide ratio", b - a, 32'(64 >> (k + 1)));
        end

        // R3: external edges
        rd_cnt(a);
        for (int k = 0; k < 5; k++) pulse();
        wait_n(4);
        rd_cnt(b);
        chk("R3 five short pulses", b - a, 32'd5);
        ext_clk = 1'b1;
        wait_n(20);
        ext_clk = 1'b0;
        wait_n(6);
        rd_cnt(a);
        chk("R3 long pulse counts once", a - b, 32'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule